// File: doc/BRIEF.md
# Two-Wire Programming Bit Shifter

This block drives a reset/clock/data pin triple toward a target device for serial programming. It serves one of several identical pin groups at a time. Every other group holds its pins where the last operation left them. A host starts one operation with a start strobe and a set of arguments. While the operation runs, `busy` is high. A one-cycle `done` marks completion, and `result` then holds the outcome until the next accepted start.

There are three operations. The direct operation sets the three pins from a 3-bit value and returns the pin levels it samples. The shift-out operation sends up to 63 bits, least significant bit first. The shift-in operation lets go of the data pin, clocks in up to 31 bits, and returns them right-justified. Every clock high phase and every clock low phase lasts a programmable number of system clocks.

Top module: `prog_shifter`

## Requirements
- R1: Direct operation (`op` = 0 or 3) drives the selected group's reset pin from `pin_val[0]`, its clock pin from `pin_val[1]` and its data pin from `pin_val[2]`, and sets the data pin to output (`dat_oe` = 1).
- R2: The direct operation samples the selected group's pins one half period after driving them. `result[0]` holds the reset level, `result[1]` the clock level and `result[2]` the data level. All higher result bits are 0.
- R3: Shift-out (`op` = 1) takes its bit count from all 6 bits of `len`, so 0 to 63. A count of 0 gives no clock pulse and raises `done` in the cycle after the start, without `busy`.
- R4: On shift-out, the data pin changes only together with a rising clock. The bit driven with the k-th rising edge is `dout_word[k]`, so the word goes out least significant bit first.
- R5: Shift-in (`op` = 2) takes its bit count from `len[4:0]` only, so 0 to 31, and `len[5]` is ignored. While a non-zero shift-in runs, the selected group's `dat_oe` is 0.
- R6: Shift-in samples data at the end of each clock high phase. The bit taken during the k-th pulse lands in `result[k]`. Result bits at and above the count are 0.
- R7: The selected group's `dat_oe` is 1 again when `done` rises at the end of a shift-in.
- R8: With `half_per` = H, each clock high phase and each low phase between pulses lasts max(H,1) system clocks.
- R9: A start that arrives while `busy` is high has no effect on any pin or on the result.
- R10: `done` is high for exactly one cycle. For a shift, that cycle is the one in which the last clock falls. `busy` is low in that cycle, and `result` and all pins stay unchanged until the next accepted start.
- R11: `sel` is sampled at start. Values 0, 1 and 2 pick that group, and 3 picks group 2. The pins of the groups not picked do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, taken when idle |
| op | input | 2 | 0/3 direct, 1 shift-out, 2 shift-in |
| sel | input | 2 | Pin group select |
| len | input | 6 | Bit count (shift-in uses bits 4:0) |
| pin_val | input | 3 | Direct levels: bit0 reset, bit1 clock, bit2 data |
| dout_word | input | 64 | Shift-out word, LSB first |
| half_per | input | 8 | Half-period in system clocks (0 acts as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Direct read-back or captured bits |
| rst_o | output | 3 | Reset pin level per group |
| clk_o | output | 3 | Clock pin level per group |
| dat_o | output | 3 | Data pin level per group |
| dat_oe | output | 3 | Data pin output enable per group |
| rst_i | input | 3 | Sampled reset pin per group |
| clk_i | input | 3 | Sampled clock pin per group |
| dat_i | input | 3 | Sampled data pin per group |

## Verification
The bench uses the default parameters: three groups, 64-bit shift-out word, 32-bit capture word, 8-bit half period. At these sizes every shift-out length from 0 to 63 and every shift-in length from 0 to 31 can be swept, with and without the ignored top length bit. Every direct value can be tried on every select code. Half periods of 0, 1, 2 and 3 are mixed through the sweeps. Pulse counts and phase lengths then have small closed forms that can be checked against the measured ones.

// File: rtl/prog_shifter.sv
module prog_shifter #(
  parameter int NGRP   = 3,
  parameter int HW     = 8,
  parameter int OUT_LW = 6,
  parameter int IN_LW  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             op,
  input  logic [1:0]             sel,
  input  logic [OUT_LW-1:0]      len,
  input  logic [2:0]             pin_val,
  input  logic [(2**OUT_LW)-1:0] dout_word,
  input  logic [HW-1:0]          half_per,
  output logic                   busy,
  output logic                   done,
  output logic [(2**IN_LW)-1:0]  result,
  output logic [NGRP-1:0]        rst_o,
  output logic [NGRP-1:0]        clk_o,
  output logic [NGRP-1:0]        dat_o,
  output logic [NGRP-1:0]        dat_oe,
  input  logic [NGRP-1:0]        rst_i,
  input  logic [NGRP-1:0]        clk_i,
  input  logic [NGRP-1:0]        dat_i
);
  localparam int OUT_W = 2**OUT_LW;
  localparam int IN_W  = 2**IN_LW;
  localparam logic [1:0] OP_OUT = 2'd1;
  localparam logic [1:0] OP_IN  = 2'd2;
  localparam logic [1:0] LAST   = 2'(NGRP-1);

  typedef enum logic [1:0] {S_IDLE, S_PIN, S_HI, S_LO} st_t;

  st_t               st;
  logic [1:0]        g;
  logic [HW-1:0]     cnt, hreg;
  logic [OUT_LW-1:0] bits;
  logic [IN_LW-1:0]  pos;
  logic [OUT_W-1:0]  sh;
  logic [IN_W-1:0]   cap;
  logic              is_in;

  logic [1:0]        gsel;
  logic [HW-1:0]     hm1;
  logic [IN_W-1:0]   capn;
  logic [OUT_LW-1:0] in_n;
  logic [2:0]        rd;

  assign gsel = (sel >= LAST) ? LAST : sel;
  assign hm1  = (half_per == '0) ? '0 : half_per - 1'b1;
  assign in_n = OUT_LW'(len[IN_LW-1:0]);
  assign capn = cap | (IN_W'(dat_i[g]) << pos);
  assign rd   = {dat_i[g], clk_i[g], rst_i[g]};
  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      g      <= '0;
      cnt    <= '0;
      hreg   <= '0;
      bits   <= '0;
      pos    <= '0;
      sh     <= '0;
      cap    <= '0;
      is_in  <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      rst_o  <= '0;
      clk_o  <= '0;
      dat_o  <= '0;
      dat_oe <= '1;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          g      <= gsel;
          hreg   <= hm1;
          cnt    <= hm1;
          result <= '0;
          cap    <= '0;
          pos    <= '0;
          if (op == OP_OUT) begin
            if (len != '0) begin
              st           <= S_HI;
              is_in        <= 1'b0;
              bits         <= len;
              clk_o[gsel]  <= 1'b1;
              dat_o[gsel]  <= dout_word[0];
              sh           <= dout_word >> 1;
            end else done <= 1'b1;
          end else if (op == OP_IN) begin
            if (in_n != '0) begin
              st           <= S_HI;
              is_in        <= 1'b1;
              bits         <= in_n;
              dat_oe[gsel] <= 1'b0;
              clk_o[gsel]  <= 1'b1;
            end else done <= 1'b1;
          end else begin
            st           <= S_PIN;
            dat_oe[gsel] <= 1'b1;
            rst_o[gsel]  <= pin_val[0];
            clk_o[gsel]  <= pin_val[1];
            dat_o[gsel]  <= pin_val[2];
          end
        end
        S_PIN: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            result <= IN_W'(rd);
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        S_HI: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            clk_o[g] <= 1'b0;
            cnt      <= hreg;
            bits     <= bits - 1'b1;
            if (is_in) begin
              cap <= capn;
              pos <= pos + 1'b1;
            end
            if (bits == OUT_LW'(1)) begin
              st   <= S_IDLE;
              done <= 1'b1;
              if (is_in) begin
                dat_oe[g] <= 1'b1;
                result    <= capn;
              end
            end else st <= S_LO;
          end
        S_LO: if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            clk_o[g] <= 1'b1;
            cnt      <= hreg;
            st       <= S_HI;
            if (!is_in) begin
              dat_o[g] <= sh[0];
              sh       <= sh >> 1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prog_shifter_chk.sv
module prog_shifter_chk #(
  parameter int NGRP   = 3,
  parameter int OUT_LW = 6,
  parameter int IN_LW  = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [1:0]            op,
  input logic [OUT_LW-1:0]     len,
  input logic                  busy,
  input logic                  done,
  input logic [(2**IN_LW)-1:0] result,
  input logic [NGRP-1:0]       rst_o,
  input logic [NGRP-1:0]       clk_o,
  input logic [NGRP-1:0]       dat_oe
);
  AST_EMPTY_OUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'd1 && len == '0) |=> (done && !busy)); // R3
  AST_IN_RELEASES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op == 2'd2 && len[IN_LW-1:0] != '0) |=> ($countones(dat_oe) == NGRP-1)); // R5
  AST_OE_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&dat_oe)); // R7
  AST_BUSY_RUNS_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done)); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(result) && $stable(clk_o) && $stable(rst_o))); // R10
endmodule

bind prog_shifter prog_shifter_chk #(.NGRP(NGRP), .OUT_LW(OUT_LW), .IN_LW(IN_LW)) u_chk (.*);

// File: tb/test_prog_shifter.sv
module test_prog_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0, sel = '0;
  logic [5:0]  len = '0;
  logic [2:0]  pin_val = '0;
  logic [63:0] dout_word = '0;
  logic [7:0]  half_per = 8'd1;
  logic        busy, done;
  logic [31:0] result;
  logic [2:0]  rst_o, clk_o, dat_o, dat_oe, rst_i, clk_i, dat_i;

  int vecs = 0, fails = 0;
  logic [2:0]  tgt = '0;
  bit          tb_in = 1'b0;
  bit          mon = 1'b0;
  int          tsel = 0;
  logic [31:0] pat = '0;
  logic [63:0] obits = '0;
  int          pulses = 0, hi = 0, lo = 0, oebad = 0, dones = 0;
  logic        prevc = 1'b0;

  always #2 clk = ~clk;

  prog_shifter i_prog_shifter (.*);

  assign rst_i = rst_o;
  assign clk_i = clk_o;
  always_comb for (int i = 0; i < 3; i++) dat_i[i] = tb_in ? tgt[i] : dat_o[i];

  always @(negedge clk) if (mon) begin
    if (clk_o[tsel] && !prevc) begin
      obits[pulses] = dat_o[tsel];
      tgt = {3{~pat[pulses]}};
      tgt[tsel] = pat[pulses];
      pulses++;
    end
    if (busy && clk_o[tsel]) hi++;
    if (busy && !clk_o[tsel]) lo++;
    if (busy && tb_in && dat_oe[tsel]) oebad++;
    if (done) dones++;
    prevc = clk_o[tsel];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [1:0] s, input logic [5:0] l,
                     input logic [2:0] v, input logic [63:0] w, input logic [7:0] h,
                     input logic [31:0] p, input bit poke);
    int ge, n, hh, cnt;
    logic [2:0] sr, sc, sd, so, oth;
    logic [31:0] hold, er;
    logic [63:0] m;
    ge = (s == 2'd3) ? 2 : int'(s);
    hh = (h == 0) ? 1 : int'(h);
    n  = (o == 2'd1) ? int'(l) : int'(l[4:0]);
    sr = rst_o; sc = clk_o; sd = dat_o; so = dat_oe;
    @(negedge clk);
    tsel = ge; pat = p; tb_in = (o == 2'd2);
    pulses = 0; hi = 0; lo = 0; oebad = 0; dones = 0; obits = '0;
    prevc = clk_o[ge]; mon = 1'b1;
    op = o; sel = s; len = l; pin_val = v; dout_word = w; half_per = h; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 20000) begin
      if (poke && cnt == 6) begin
        start = 1'b1; op = 2'd0; sel = 2'((ge + 1) % 3); pin_val = 3'd7;
      end else start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(cnt < 20000, "R10", "done seen", cnt, 0);
    chk(!busy, "R10", "busy low at done", busy, 0);
    @(negedge clk);
    mon = 1'b0;
    chk(!done && dones == 1, "R10", "done one cycle", dones, 1);
    oth = ((rst_o ^ sr) | (clk_o ^ sc) | (dat_o ^ sd) | (dat_oe ^ so)) & ~(3'b1 << ge);
    chk(oth == 0, poke ? "R9" : "R11", "other groups untouched", oth, 0);
    if (o == 2'd1 || o == 2'd2) begin
      m = (64'd1 << n) - 64'd1;
      chk(pulses == n, o == 2'd1 ? "R3" : "R5", "pulse count", pulses, n);
      chk(clk_o[ge] == 1'b0, "R10", "clock low at end", clk_o[ge], 0);
      chk(hi == n * hh, "R8", "high cycles", hi, n * hh);
      if (n > 0) chk(lo == (n - 1) * hh, "R8", "low cycles", lo, (n - 1) * hh);
    end
    if (o == 2'd1) begin
      chk(((obits ^ w) & m) == 0, "R4", "shifted bits", obits & m, w & m);
      chk(result == 0, "R10", "result after out", result, 0);
    end else if (o == 2'd2) begin
      er = 32'(p & m);
      chk(result == er, "R6", "captured word", result, er);
      chk(oebad == 0, "R5", "data released", oebad, 0);
      chk(dat_oe[ge] == 1'b1, "R7", "data output again", dat_oe[ge], 1);
    end else begin
      chk({dat_o[ge], clk_o[ge], rst_o[ge]} == v && dat_oe[ge], "R1", "driven pins",
          {dat_oe[ge], dat_o[ge], clk_o[ge], rst_o[ge]}, {1'b1, v});
      chk(result == {29'd0, v}, "R2", "read-back", result, v);
    end
    hold = result;
    repeat (3) @(negedge clk);
    chk(result == hold && !done, "R10", "result held", result, hold);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 0, "R10", "reset outputs", {busy, done}, 0);
    chk(dat_oe == 3'b111 && clk_o == 0 && rst_o == 0, "R1", "reset pins", {dat_oe, clk_o, rst_o}, 9'h1c0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int h = 1; h <= 3; h += 2)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 8; v++)
          run(2'(v % 2 == 0 ? 0 : 3), 2'(s), 6'd0, 3'(v), 64'd0, 8'(h), 32'd0, 1'b0);
    for (int s = 0; s < 3; s++) run(2'd0, 2'(s), 6'd0, 3'd0, 64'd0, 8'd1, 32'd0, 1'b0);
    for (int n = 0; n < 64; n++)
      run(2'd1, 2'(n % 4), 6'(n), 3'd0, 64'h9E37_79B9_7F4A_7C15 * 64'(n + 1),
          8'(n % 5 == 0 ? 0 : (n % 4 == 3 ? 2 : 1)), 32'd0, 1'b0);
    for (int n = 0; n < 32; n++)
      for (int t = 0; t < 2; t++)
        run(2'd2, 2'((n + t) % 4), 6'(n + 32 * t), 3'd0, 64'd0, 8'(n % 3 + 1),
            32'hB4E1_29D7 ^ (32'h0101_0101 * 32'(n + 3 * t)), 1'b0);
    run(2'd1, 2'd0, 6'd10, 3'd0, 64'h2D5, 8'd2, 32'd0, 1'b1);
    run(2'd2, 2'd1, 6'd12, 3'd0, 64'd0, 8'd2, 32'h0000_0A6C, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule